// File: doc/BRIEF.md
# Configuration-Space Serial EEPROM Bit-Bang Port

This block lets host software reach a 64-word by 16-bit Microwire-style serial EEPROM using only side effects of configuration-space accesses. Software toggles the EEPROM pins by writing a byte to one of two trigger offsets. A write to the select offset drives chip select high and takes the serial clock and data-in levels from the top two bits of the byte. A write to the deselect offset drives all three pins low. Neither trigger write reaches normal configuration space. Every other write is forwarded unchanged.

Software reads the EEPROM data-out line through a single-byte read of configuration offset 0. When data-out is low, that byte reads as zero. In all other cases the normal configuration data passes through untouched.

After reset, an init engine writes the default image into the EEPROM array, one word per cycle. The last word it writes is a checksum, chosen so that all 64 words sum to a fixed signature. Until the engine finishes, the pins stay low and trigger writes are ignored.

Top module: `cfg_eeprom_port`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `ee_cs`, `ee_sk`, `ee_di` and `init_done` are all 0.
- R2: After reset, the init engine asserts `img_we` for exactly 64 consecutive cycles, with `img_addr` counting 0 to 63 in order. `init_done` rises in the cycle after the last write.
- R3: Image words 0 to 15 are 0x0057: low byte 0x57, high byte 0x00.
- R4: Word 32 is 0x0F07 (adapter ID 7 in the low byte, mode byte 0x0F in the high byte). Word 33 is 0x0400 (tag count 4 in the high byte). Word 34 is 0x0007, where option bits 0, 1 and 2 are set and bit 3 is clear. All other words below 63 are 0.
- R5: Word 63 equals 0x1234 minus the modulo-2^16 sum of words 0 to 62, which is 0xF9B6 for the default image.
- R6: Once `init_done` is 1, a write to offset 0x80 makes `ee_cs`=1, `ee_sk`=`cfg_wdata_hi[1]` (data bit 7) and `ee_di`=`cfg_wdata_hi[0]` (data bit 6) from the next cycle on. `cfg_fwd_we` stays 0 for that write.
- R7: Once `init_done` is 1, a write to offset 0xC0 drives all three pins to 0 from the next cycle on. `cfg_fwd_we` stays 0 for that write.
- R8: A write to any other offset raises `cfg_fwd_we` in the same cycle and leaves the pins unchanged.
- R9: When `cfg_rd_byte`=1, `cfg_addr`=0 and `ee_do`=0, `cfg_rdata_out` equals `cfg_rdata_in` with bits 7:0 forced to 0. In every other case it equals `cfg_rdata_in`.
- R10: Before `init_done` rises, writes to 0x80 or 0xC0 leave the pins low and are still not forwarded.
- R11: Once `init_done` is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset for the access |
| cfg_wdata_hi | input | 2 | Bits 7:6 of the write data byte |
| cfg_fwd_we | output | 1 | Write strobe forwarded to normal config space |
| cfg_rd_byte | input | 1 | Current read is a single-byte read |
| cfg_rdata_in | input | 32 | Read data from normal config space |
| cfg_rdata_out | output | 32 | Read data returned to the host |
| ee_do | input | 1 | EEPROM serial data-out line |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data-in |
| img_we | output | 1 | Default-image write strobe to the EEPROM array |
| img_addr | output | 6 | Default-image word address |
| img_wdata | output | 16 | Default-image word data |
| init_done | output | 1 | Default image and checksum have been written |

## Verification
The bench builds the block with its default parameters. These are 64 words, trigger offsets 0x80 and 0xC0, and signature 0x1234. With these values, the complete default image and its checksum word 0xF9B6 can be checked word by word against values the bench computes on its own. The defaults also allow trigger writes to be issued while the init engine is still busy, so that the hold-off window is exercised. Pin-level sequences with every combination of bits 7 and 6 are exercised, along with writes to neighbouring offsets such as 0x81.

// File: rtl/cfg_eeprom_pkg.sv
package cfg_eeprom_pkg;
  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ee_pins_t;

  localparam int unsigned WORD_W = 16;
endpackage

// File: rtl/cfg_eeprom_init.sv
module cfg_eeprom_init
  import cfg_eeprom_pkg::*;
#(
  parameter int unsigned WORDS      = 64,
  parameter logic [15:0] SIG        = 16'h1234,
  parameter logic [7:0]  FILL_BYTE  = 8'h57,
  parameter int unsigned FILL_WORDS = 16,
  parameter logic [7:0]  ID_BYTE    = 8'h07,
  parameter logic [7:0]  MODE_BYTE  = 8'h0F,
  parameter logic [7:0]  TAG_BYTE   = 8'h04,
  parameter logic [7:0]  OPT_BYTE   = 8'h07,
  localparam int unsigned AW        = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              img_we,
  output logic [AW-1:0]     img_addr,
  output logic [WORD_W-1:0] img_wdata,
  output logic              init_done
);
  localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);
  localparam logic [AW-1:0] ID_IDX   = AW'(32);
  localparam logic [AW-1:0] FILL_END = AW'(FILL_WORDS);

  logic [AW-1:0]     idx_q, idx_n;
  logic [WORD_W-1:0] sum_q, sum_n;
  logic              busy_q, busy_n;
  logic              done_q, done_n;
  logic [WORD_W-1:0] word_c;
  logic              last_c;

  // default content per word index
  always_comb begin
    if (idx_q < FILL_END)            word_c = {8'h00, FILL_BYTE};
    else if (idx_q == ID_IDX)        word_c = {MODE_BYTE, ID_BYTE};
    else if (idx_q == ID_IDX + 1'b1) word_c = {TAG_BYTE, 8'h00};
    else if (idx_q == ID_IDX + 2'd2) word_c = {8'h00, OPT_BYTE};
    else                             word_c = '0;
  end

  assign last_c = (idx_q == LAST_IDX);

  always_comb begin
    idx_n  = idx_q;
    sum_n  = sum_q;
    busy_n = busy_q;
    done_n = done_q;
    if (busy_q) begin
      idx_n = idx_q + 1'b1;
      sum_n = sum_q + word_c;
      if (last_c) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      sum_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      sum_q  <= sum_n;
      busy_q <= busy_n | (~busy_q & ~done_q);
      done_q <= done_n;
    end
  end

  // the first cycle out of reset arms the engine; writes start one cycle later
  assign img_we    = busy_q;
  assign img_addr  = idx_q;
  assign img_wdata = last_c ? (SIG - sum_q) : word_c;
  assign init_done = done_q;
endmodule

// File: rtl/cfg_eeprom_pins.sv
module cfg_eeprom_pins
  import cfg_eeprom_pkg::*;
#(
  parameter logic [7:0] SEL_OFS   = 8'h80,
  parameter logic [7:0] DESEL_OFS = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [1:0] wdata_hi,
  output ee_pins_t   pins,
  output logic       fwd_we
);
  logic     hit_sel, hit_desel, pin_en;
  ee_pins_t pins_q, pins_n;

  assign hit_sel   = wr_en && (addr == SEL_OFS);
  assign hit_desel = wr_en && (addr == DESEL_OFS);
  assign pin_en    = enable && (hit_sel || hit_desel);
  assign fwd_we    = wr_en && !(addr == SEL_OFS) && !(addr == DESEL_OFS);

  always_comb begin
    pins_n = pins_q;
    if (hit_sel) begin
      pins_n.cs = 1'b1;
      pins_n.sk = wdata_hi[1];
      pins_n.di = wdata_hi[0];
    end else begin
      pins_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pins_q <= '0;
    else if (pin_en) pins_q <= pins_n;
  end

  assign pins = pins_q;
endmodule

// File: rtl/cfg_eeprom_rdgate.sv
module cfg_eeprom_rdgate #(
  parameter int unsigned DW = 32
) (
  input  logic          rd_byte,
  input  logic [7:0]    addr,
  input  logic          ee_do,
  input  logic [DW-1:0] rdata_in,
  output logic [DW-1:0] rdata_out
);
  logic gate_c;
  assign gate_c    = rd_byte && (addr == 8'h00) && !ee_do;
  assign rdata_out = gate_c ? {rdata_in[DW-1:8], 8'h00} : rdata_in;
endmodule

// File: rtl/cfg_eeprom_port.sv
module cfg_eeprom_port
  import cfg_eeprom_pkg::*;
#(
  parameter int unsigned WORDS     = 64,
  parameter logic [7:0]  SEL_OFS   = 8'h80,
  parameter logic [7:0]  DESEL_OFS = 8'hC0,
  parameter logic [15:0] SIG       = 16'h1234,
  localparam int unsigned AW       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_addr,
  input  logic [1:0]        cfg_wdata_hi,
  output logic              cfg_fwd_we,
  input  logic              cfg_rd_byte,
  input  logic [31:0]       cfg_rdata_in,
  output logic [31:0]       cfg_rdata_out,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              img_we,
  output logic [AW-1:0]     img_addr,
  output logic [WORD_W-1:0] img_wdata,
  output logic              init_done
);
  ee_pins_t pins;

  cfg_eeprom_init #(.WORDS(WORDS), .SIG(SIG)) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .img_we    (img_we),
    .img_addr  (img_addr),
    .img_wdata (img_wdata),
    .init_done (init_done)
  );

  cfg_eeprom_pins #(.SEL_OFS(SEL_OFS), .DESEL_OFS(DESEL_OFS)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (init_done),
    .wr_en    (cfg_wr_en),
    .addr     (cfg_addr),
    .wdata_hi (cfg_wdata_hi),
    .pins     (pins),
    .fwd_we   (cfg_fwd_we)
  );

  cfg_eeprom_rdgate #(.DW(32)) u_rdgate (
    .rd_byte   (cfg_rd_byte),
    .addr      (cfg_addr),
    .ee_do     (ee_do),
    .rdata_in  (cfg_rdata_in),
    .rdata_out (cfg_rdata_out)
  );

  assign ee_cs = pins.cs;
  assign ee_sk = pins.sk;
  assign ee_di = pins.di;
endmodule

// File: rtl/cfg_eeprom_port_chk.sv
module cfg_eeprom_port_chk #(
  parameter logic [7:0] SEL_OFS   = 8'h80,
  parameter logic [7:0] DESEL_OFS = 8'hC0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [7:0]  cfg_addr,
  input logic [1:0]  cfg_wdata_hi,
  input logic        cfg_fwd_we,
  input logic        cfg_rd_byte,
  input logic [31:0] cfg_rdata_in,
  input logic [31:0] cfg_rdata_out,
  input logic        ee_do,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di,
  input logic        img_we,
  input logic        init_done
);
  assert_we_excl_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    img_we |-> !init_done);

  assert_sel_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cfg_wr_en && cfg_addr == SEL_OFS)
    |=> (ee_cs && ee_sk == $past(cfg_wdata_hi[1]) && ee_di == $past(cfg_wdata_hi[0])));

  assert_desel_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && cfg_wr_en && cfg_addr == DESEL_OFS) |=> (!ee_cs && !ee_sk && !ee_di));

  assert_trigger_not_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && (cfg_addr == SEL_OFS || cfg_addr == DESEL_OFS)) |-> !cfg_fwd_we);

  assert_other_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr != SEL_OFS && cfg_addr != DESEL_OFS)
    |=> ($stable(ee_cs) && $stable(ee_sk) && $stable(ee_di)));

  assert_rd_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_byte && cfg_addr == 8'h00 && !ee_do)
    |-> (cfg_rdata_out == {cfg_rdata_in[31:8], 8'h00}));

  assert_pins_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!ee_cs && !ee_sk && !ee_di));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

bind cfg_eeprom_port cfg_eeprom_port_chk #(.SEL_OFS(SEL_OFS), .DESEL_OFS(DESEL_OFS)) u_chk (.*);

// File: tb/cfg_eeprom_port_bench.sv
module cfg_eeprom_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_addr;
  logic [1:0]  cfg_wdata_hi;
  logic        cfg_fwd_we;
  logic        cfg_rd_byte;
  logic [31:0] cfg_rdata_in;
  logic [31:0] cfg_rdata_out;
  logic        ee_do, ee_cs, ee_sk, ee_di;
  logic        img_we;
  logic [5:0]  img_addr;
  logic [15:0] img_wdata;
  logic        init_done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [15:0] got_img [64];
  logic [15:0] exp_img [64];
  int          wr_count = 0;
  int          order_bad = 0;

  always #10 clk = ~clk;

  cfg_eeprom_port u_cfg_eeprom_port (.*);

  // vector: {addr, data byte, exp cs, sk, di, exp fwd}
  localparam logic [19:0] VEC [10] = '{
    {8'h80, 8'hC0, 4'b1110},
    {8'h80, 8'h80, 4'b1100},
    {8'h80, 8'h40, 4'b1010},
    {8'h80, 8'h3F, 4'b1000},
    {8'h10, 8'hFF, 4'b1001},
    {8'hC0, 8'hFF, 4'b0000},
    {8'h00, 8'hC0, 4'b0001},
    {8'h80, 8'hFF, 4'b1110},
    {8'h81, 8'h00, 4'b1111},
    {8'hC0, 8'h00, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // capture image writes away from the edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && img_we) begin
      if (img_addr != wr_count[5:0]) order_bad++;
      got_img[img_addr] = img_wdata;
      wr_count++;
    end
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d, output logic fwd);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata_hi = d[7:6];
    #1 fwd = cfg_fwd_we;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_addr = 8'h44;
    #1;
  endtask

  initial begin
    logic [15:0] sum;
    logic        fwd;
    cfg_wr_en = 0; cfg_addr = 8'h44; cfg_wdata_hi = 0;
    cfg_rd_byte = 0; cfg_rdata_in = 32'h1234_56A5; ee_do = 1;
    rst_n = 0;
    for (int i = 0; i < 64; i++) got_img[i] = 16'hxxxx;
    // expected image from the requirements
    for (int i = 0; i < 64; i++) exp_img[i] = 16'h0000;
    for (int i = 0; i < 16; i++) exp_img[i] = 16'h0057;   // R3
    exp_img[32] = 16'h0F07; exp_img[33] = 16'h0400; exp_img[34] = 16'h0007; // R4
    sum = 16'h0000;
    for (int i = 0; i < 63; i++) sum = sum + exp_img[i];
    exp_img[63] = 16'h1234 - sum;                          // R5

    repeat (3) @(negedge clk);
    check("R1 reset pins", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    check("R1 reset done", {31'd0, init_done}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {28'd0, ee_cs, ee_sk, ee_di, init_done}, 32'd0);

    // R10: trigger writes during init
    cfg_write(8'h80, 8'hC0, fwd);
    check("R10 sel not forwarded", {31'd0, fwd}, 32'd0);
    check("R10 pins held low", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    cfg_write(8'hC0, 8'h00, fwd);
    check("R10 desel not forwarded", {31'd0, fwd}, 32'd0);

    for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
    check("R2 write count", wr_count, 64);
    check("R2 address order", order_bad, 0);
    check("R2 done raised", {31'd0, init_done}, 32'd1);
    for (int i = 0; i < 64; i++) begin
      if (i < 16)      check("R3 fill word", {16'd0, got_img[i]}, {16'd0, exp_img[i]});
      else if (i < 63) check("R4 option word", {16'd0, got_img[i]}, {16'd0, exp_img[i]});
      else             check("R5 checksum", {16'd0, got_img[i]}, 32'h0000_F9B6);
    end

    for (int v = 0; v < 10; v++) begin
      cfg_write(VEC[v][19:12], VEC[v][11:4], fwd);
      if (VEC[v][0]) check("R8 forward", {31'd0, fwd}, 32'd1);
      else           check("R6 R7 trigger not forwarded", {31'd0, fwd}, {31'd0, VEC[v][0]});
      if (VEC[v][19:12] == 8'h80)      check("R6 pins", {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, VEC[v][3:1]});
      else if (VEC[v][19:12] == 8'hC0) check("R7 pins", {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, VEC[v][3:1]});
      else                             check("R8 pins unchanged", {29'd0, ee_cs, ee_sk, ee_di}, {29'd0, VEC[v][3:1]});
    end

    // R9 read gating
    cfg_addr = 8'h00; cfg_rd_byte = 1; ee_do = 0; #1;
    check("R9 gated byte", cfg_rdata_out, 32'h1234_5600);
    ee_do = 1; #1;
    check("R9 do high", cfg_rdata_out, 32'h1234_56A5);
    ee_do = 0; cfg_addr = 8'h04; #1;
    check("R9 other offset", cfg_rdata_out, 32'h1234_56A5);
    cfg_addr = 8'h00; cfg_rd_byte = 0; #1;
    check("R9 wide read", cfg_rdata_out, 32'h1234_56A5);
    cfg_rd_byte = 0; cfg_addr = 8'h44;

    repeat (5) @(negedge clk);
    check("R11 done sticky", {31'd0, init_done}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule